// File: doc/BRIEF.md
# Fault and Soft-Start Restart Sequencer

This block supervises the start-up and fault recovery of a switching power stage. It watches a sampled supply voltage, given in millivolts, and applies an undervoltage lockout with hysteresis. One of two threshold pairs is chosen by a variant select. A soft-reference counter stands in for the reference voltage, also in millivolts. The counter climbs in large steps during soft-start and falls in small steps while a restart delay is being timed. The gate-drive enable is only granted when the supply is good, the internal rail is good, and no fault is latched.

Two latches work together to control recovery: a fault latch and a delay latch. A fault shuts the drive off at once. The restart delay then begins from wherever the soft-reference stands. After a fault in normal running, the counter is near full scale and the delay begins right away. After a fault during soft-start, the ramp continues until the counter reaches the delay level, and only then does the delay begin. A latch-off option freezes the discharge, so a fault keeps the stage off until the supply has passed through undervoltage again.

Top module: `softstart_supervisor`

## Requirements
- R1: Undervoltage lockout has hysteresis. It releases when `vcc_mv` >= the turn-on level and engages when `vcc_mv` < the turn-off level. With `low_uv_sel`=0 the levels are 16500/10500 mV. With `low_uv_sel`=1 they are 8000/7000 mV. `uvlo` follows the supply one clock edge after the sample.
- R2: While `uvlo` is high, both the fault latch and the delay latch are set at every clock edge.
- R3: `drive_en` is high exactly when `uvlo` is low, `rail_ok` is high and `fault_latch` is low. It responds to `rail_ok` combinationally.
- R4: When `fault_in` is high at an edge, `fault_latch` is set at that edge. If `sref` is >= 4000 at that edge, `delay_latch` is set at the same edge.
- R5: When the fault latch is set while `sref` < 4000, the delay latch stays clear while the counter keeps ramping. The delay latch sets at the first edge where `sref` is >= 4000.
- R6: While the delay latch is set, and latch-off is off or `uvlo` is high, `sref` drops by 20 at each edge and saturates at 0.
- R7: At an edge where the delay latch is set, `sref` is 0 and `fault_in` is low, both latches clear. A `fault_in` held high keeps them set.
- R8: While the delay latch is clear, `sref` rises by 500 at each edge and saturates at 5000.
- R9: With `latch_off` high and `uvlo` low, a set delay latch holds `sref` unchanged, so the stage stays off until the supply passes through undervoltage.
- R10: After reset, `uvlo`, `fault_latch` and `delay_latch` are 1, `sref` is 0 and `drive_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_mv | input | 16 | Sampled supply voltage in mV |
| fault_in | input | 1 | Fault detected, active high |
| rail_ok | input | 1 | Internal rail above its good level |
| low_uv_sel | input | 1 | 0: 16.5/10.5 V lockout, 1: 8/7 V lockout |
| latch_off | input | 1 | Block restart after a fault |
| sref | output | 13 | Soft-reference level in mV, 0 to 5000 |
| drive_en | output | 1 | Gate-drive enable |
| uvlo | output | 1 | Undervoltage lockout active |
| fault_latch | output | 1 | Fault latch state |
| delay_latch | output | 1 | Restart delay latch state |

## Verification
Every state output is a single register, so each result is due one edge after the input or state that causes it. The exception is `drive_en`, which follows `rail_ok` with no delay. Inputs change on the falling edge and outputs are sampled on the next falling edge. This lets each check count edges exactly: one edge for a lockout change, two edges from lockout release to latch clear, 250 edges of discharge from full scale, and the set-at-4000 edge after a soft-start fault. Long waits are counted in edges, and the bench checks the exact count at which the fault latch clears.

// File: rtl/softstart_supervisor.sv
module softstart_supervisor #(
  parameter int VW        = 16,
  parameter int VMAX      = 5000,
  parameter int CHG_STEP  = 500,
  parameter int DIS_STEP  = 20,
  parameter int DLY_LEVEL = 4000,
  parameter int HI_ON     = 16500,
  parameter int HI_OFF    = 10500,
  parameter int LO_ON     = 8000,
  parameter int LO_OFF    = 7000,
  localparam int SW       = $clog2(VMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vcc_mv,
  input  logic          fault_in,
  input  logic          rail_ok,
  input  logic          low_uv_sel,
  input  logic          latch_off,
  output logic [SW-1:0] sref,
  output logic          drive_en,
  output logic          uvlo,
  output logic          fault_latch,
  output logic          delay_latch
);
  logic [VW-1:0] on_lvl, off_lvl;
  logic          fl_set, release_ok, dl_next;

  assign on_lvl  = low_uv_sel ? VW'(LO_ON)  : VW'(HI_ON);
  assign off_lvl = low_uv_sel ? VW'(LO_OFF) : VW'(HI_OFF);

  assign fl_set     = fault_latch | fault_in;
  assign release_ok = delay_latch && (sref == '0) && !fault_in;
  assign dl_next    = delay_latch | (fl_set && (sref >= SW'(DLY_LEVEL)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uvlo <= 1'b1;
    else if (uvlo) uvlo <= (vcc_mv < on_lvl);
    else           uvlo <= (vcc_mv < off_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_latch <= 1'b1;
      delay_latch <= 1'b1;
    end else if (uvlo) begin
      fault_latch <= 1'b1;
      delay_latch <= 1'b1;
    end else if (release_ok) begin
      fault_latch <= 1'b0;
      delay_latch <= 1'b0;
    end else begin
      fault_latch <= fl_set;
      delay_latch <= dl_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sref <= '0;
    else if (delay_latch) begin
      if (!latch_off || uvlo)
        sref <= (sref > SW'(DIS_STEP)) ? sref - SW'(DIS_STEP) : '0;
    end else begin
      sref <= (sref >= SW'(VMAX - CHG_STEP)) ? SW'(VMAX) : sref + SW'(CHG_STEP);
    end
  end

  assign drive_en = !uvlo && rail_ok && !fault_latch;
endmodule

module softstart_supervisor_chk #(
  parameter int SW       = 13,
  parameter int VMAX     = 5000,
  parameter int CHG_STEP = 500,
  parameter int DIS_STEP = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_in,
  input logic          rail_ok,
  input logic          latch_off,
  input logic [SW-1:0] sref,
  input logic          drive_en,
  input logic          uvlo,
  input logic          fault_latch,
  input logic          delay_latch
);
  // R2
  uv_sets_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (fault_latch && delay_latch));
  // R3
  enable_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (!uvlo && rail_ok && !fault_latch));
  // R4
  fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> fault_latch);
  // R6
  discharge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_latch && !latch_off && sref >= SW'(DIS_STEP)) |=> (sref == $past(sref) - SW'(DIS_STEP)));
  // R8
  charge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!delay_latch && sref <= SW'(VMAX - CHG_STEP)) |=> (sref == $past(sref) + SW'(CHG_STEP)));
  // R8
  sref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sref <= SW'(VMAX));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_latch && latch_off && !uvlo) |=> $stable(sref));
endmodule

bind softstart_supervisor softstart_supervisor_chk #(
  .SW(SW), .VMAX(VMAX), .CHG_STEP(CHG_STEP), .DIS_STEP(DIS_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .rail_ok(rail_ok),
  .latch_off(latch_off), .sref(sref), .drive_en(drive_en), .uvlo(uvlo),
  .fault_latch(fault_latch), .delay_latch(delay_latch)
);

// File: tb/tb_softstart_supervisor.sv
module tb_softstart_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] vcc_mv = 16'd12000;
  logic        fault_in = 1'b0, rail_ok = 1'b1, low_uv_sel = 1'b0, latch_off = 1'b0;
  logic [12:0] sref;
  logic        drive_en, uvlo, fault_latch, delay_latch;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  softstart_supervisor dut (
    .clk(clk), .rst_n(rst_n), .vcc_mv(vcc_mv), .fault_in(fault_in), .rail_ok(rail_ok),
    .low_uv_sel(low_uv_sel), .latch_off(latch_off), .sref(sref), .drive_en(drive_en),
    .uvlo(uvlo), .fault_latch(fault_latch), .delay_latch(delay_latch)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R10 uvlo", uvlo, 1); chk("R10 fault", fault_latch, 1);
    chk("R10 delay", delay_latch, 1); chk("R10 sref", sref, 0);
    chk("R10 en", drive_en, 0);
  endtask

  task automatic t_powerup();
    tick(3);
    chk("R1 below on level", uvlo, 1);
    vcc_mv = 16'd16500;
    tick();
    chk("R1 release at on level", uvlo, 0);
    chk("R2 latches kept", fault_latch, 1);
    tick();
    chk("R7 release after uv", fault_latch, 0);
    chk("R7 delay clear", delay_latch, 0);
    chk("R3 en high", drive_en, 1);
    rail_ok = 1'b0; #1;
    chk("R3 rail low", drive_en, 0);
    rail_ok = 1'b1; #1;
    tick();
    chk("R8 first step", sref, 500);
    tick(9);
    chk("R8 full", sref, 5000);
    tick();
    chk("R8 saturate", sref, 5000);
  endtask

  task automatic t_run_fault();
    int k;
    fault_in = 1'b1;
    tick();
    fault_in = 1'b0;
    chk("R4 fault latch", fault_latch, 1);
    chk("R4 delay latch", delay_latch, 1);
    chk("R4 en off", drive_en, 0);
    tick();
    chk("R6 step", sref, 4980);
    k = 1;
    while (fault_latch && k < 400) begin tick(); k++; end
    chk("R7 restart edges", k, 251);
    chk("R7 en back", drive_en, 1);
  endtask

  task automatic t_held_fault();
    tick(12);
    fault_in = 1'b1;
    tick(260);
    chk("R6 saturate zero", sref, 0);
    chk("R7 held fault", fault_latch, 1);
    fault_in = 1'b0;
    tick();
    chk("R7 clear on drop", fault_latch, 0);
  endtask

  task automatic t_softstart_fault();
    tick(2);
    chk("R8 ramp", sref, 1000);
    fault_in = 1'b1;
    tick();
    fault_in = 1'b0;
    chk("R5 fault set", fault_latch, 1);
    chk("R5 delay clear", delay_latch, 0);
    chk("R5 ramp on", sref, 1500);
    tick(5);
    chk("R5 at level", sref, 4000);
    chk("R5 still clear", delay_latch, 0);
    tick();
    chk("R5 delay set", delay_latch, 1);
    chk("R5 overshoot", sref, 4500);
    begin
      int k = 0;
      while (fault_latch && k < 400) begin tick(); k++; end
      chk("R6 delay edges", k, 226);
    end
  endtask

  task automatic t_latch_off();
    tick(12);
    latch_off = 1'b1;
    fault_in = 1'b1;
    tick();
    fault_in = 1'b0;
    tick(300);
    chk("R9 sref held", sref, 5000);
    chk("R9 stays off", fault_latch, 1);
    vcc_mv = 16'd5000;
    tick();
    chk("R1 off below", uvlo, 1);
    tick(260);
    chk("R9 uv discharges", sref, 0);
    vcc_mv = 16'd17000;
    tick(2);
    chk("R9 restart after cycle", drive_en, 1);
    latch_off = 1'b0;
  endtask

  task automatic t_hyst();
    vcc_mv = 16'd10600; tick();
    chk("R1 hi hysteresis", uvlo, 0);
    vcc_mv = 16'd10400; tick();
    chk("R1 hi off", uvlo, 1);
    chk("R3 en uv", drive_en, 0);
    tick();
    chk("R2 both set", fault_latch + delay_latch, 2);
    low_uv_sel = 1'b1;
    vcc_mv = 16'd7900; tick();
    chk("R1 lo below on", uvlo, 1);
    vcc_mv = 16'd8000; tick();
    chk("R1 lo on", uvlo, 0);
    vcc_mv = 16'd7000; tick();
    chk("R1 lo hysteresis", uvlo, 0);
    vcc_mv = 16'd6999; tick();
    chk("R1 lo off", uvlo, 1);
  endtask

  initial begin
    fork
      begin
        tick(2);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_powerup();
        t_run_fault();
        t_held_fault();
        t_softstart_fault();
        t_latch_off();
        t_hyst();
      end
      begin
        wait (cyc >= 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule